// File: doc/BRIEF.md
# Consistency-Model Memory Issue Gate

This block sits between a core's in-order stream of memory operations and a memory system that keeps several requests in flight and may finish them in any order. Each operation carries a class tag: ordinary, sync, acquire or release. The gate checks the operation at the head of the stream against per-class counts of outstanding requests. It holds that operation, and so every younger one behind it, until the earlier operations it depends on have completed.

A mode input picks one of two rule sets. Weak ordering treats every special class as a full barrier. Release ordering lets ordinary accesses and acquires run past an outstanding release. Acquires and releases then keep load/store-style processor ordering among themselves. Completions come back tagged with their class and decrement the matching counter. A mode change is held back until the memory system is empty.

Top module: `mem_issue_gate`

## Requirements
- R1: The class encoding on opClass and cplClass is 0 ordinary, 1 sync, 2 acquire and 3 release. In weak mode (modeActive 0), an ordinary operation is not ready while any sync, acquire or release is outstanding.
- R2: In weak mode, a sync, acquire or release is not ready while any ordinary operation is outstanding.
- R3: In weak mode, a sync, acquire or release is not ready while any sync, acquire or release is outstanding.
- R4: In release mode (modeActive 1), an ordinary operation is not ready while any acquire or sync is outstanding.
- R5: In release mode, a release or sync is not ready while any operation of any class is outstanding.
- R6: In release mode, an ordinary operation is ready even when releases are outstanding.
- R7: In release mode, an acquire waits only for outstanding acquires and syncs. It may pass outstanding releases and ordinary operations.
- R8: pendCount holds one CNT_W-bit count per class, with ordinary in bits [3:0], sync in [7:4], acquire in [11:8] and release in [15:12] for the default width. A count rises by one the cycle after an issue of its class and falls by one after a completion of its class. An issue and a completion of the same class in one cycle leave the count unchanged.
- R9: An operation whose class counter is at its maximum value is not ready, so no counter wraps.
- R10: A completion for a class whose count is zero is ignored.
- R11: modeActive takes the value of modeSel at a clock edge only when all counts are zero at that edge. Otherwise it holds.
- R12: After reset all counts are zero and modeActive is 0. issueValid equals opValid AND opReady, and issueClass equals opClass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeSel | input | 1 | Requested rule set: 0 weak, 1 release |
| opValid | input | 1 | Head operation present |
| opClass | input | 2 | Class of the head operation |
| opReady | output | 1 | Head operation may issue this cycle |
| issueValid | output | 1 | Operation sent to memory this cycle |
| issueClass | output | 2 | Class of the operation sent to memory |
| cplValid | input | 1 | Completion response present |
| cplClass | input | 2 | Class tag of the completion |
| modeActive | output | 1 | Rule set currently in force |
| pendCount | output | 4*CNT_W | Outstanding count per class |

## Verification
On every cycle, the assertions check the stall rules of both modes against the visible counts. They also check the one-step counter updates, that no counter wraps or underflows, that the mode holds while anything is in flight, and the issue handshake. Only the bench scenarios can show the behaviour that needs a history: that ordinary accesses and acquires really overtake an outstanding release, and that a mode request made while traffic drains takes effect on the first empty cycle. The same holds for the counter saturating after fifteen issues and then draining back to zero.

// File: rtl/mig_pkg.sv
package mig_pkg;
  localparam int NUM_CLS = 4;

  typedef enum logic [1:0] {
    CLS_ORD  = 2'd0,
    CLS_SYNC = 2'd1,
    CLS_ACQ  = 2'd2,
    CLS_REL  = 2'd3
  } opClass_e;

  // strobes from control to counter bank
  typedef struct packed {
    logic [NUM_CLS-1:0] inc;
    logic [NUM_CLS-1:0] dec;
  } cntStrobe_t;
endpackage

// File: rtl/mig_cnt_bank.sv
module mig_cnt_bank
  import mig_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  cntStrobe_t               strobe,
  output logic [NUM_CLS*CNT_W-1:0] pendCount,
  output logic [NUM_CLS-1:0]       cntBusy,
  output logic [NUM_CLS-1:0]       cntFull
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  for (genvar g = 0; g < NUM_CLS; g++) begin : g_cnt
    logic [CNT_W-1:0] cntQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
      end else begin
        case ({strobe.inc[g], strobe.dec[g]})
          2'b10:   cntQ <= cntQ + 1'b1;
          2'b01:   cntQ <= cntQ - 1'b1;
          default: cntQ <= cntQ;
        endcase
      end
    end

    assign pendCount[g*CNT_W +: CNT_W] = cntQ;
    assign cntBusy[g] = (cntQ != '0);
    assign cntFull[g] = (cntQ == CNT_MAX);
  end
endmodule

// File: rtl/mig_issue_ctrl.sv
module mig_issue_ctrl
  import mig_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               modeSel,
  input  logic               opValid,
  input  logic [1:0]         opClass,
  input  logic               cplValid,
  input  logic [1:0]         cplClass,
  input  logic [NUM_CLS-1:0] cntBusy,
  input  logic [NUM_CLS-1:0] cntFull,
  output logic               opReady,
  output logic               issueValid,
  output logic               modeActive,
  output cntStrobe_t         strobe
);
  logic [NUM_CLS-1:0] blockMask;
  opClass_e headCls;

  assign headCls = opClass_e'(opClass);

  // rule set switches only with nothing in flight
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeActive <= 1'b0;
    end else if (~|cntBusy) begin
      modeActive <= modeSel;
    end
  end

  // which counters block the head class; bit index = class code
  always_comb begin
    blockMask = '1;
    if (!modeActive) begin
      if (headCls == CLS_ORD) blockMask = 4'b1110;
    end else begin
      case (headCls)
        CLS_ORD:  blockMask = 4'b0110;
        CLS_ACQ:  blockMask = 4'b0110;
        default:  blockMask = 4'b1111;
      endcase
    end
  end

  assign opReady    = ~|(blockMask & cntBusy) & ~cntFull[opClass];
  assign issueValid = opValid & opReady;

  always_comb begin
    strobe = '0;
    strobe.inc[opClass]  = issueValid;
    strobe.dec[cplClass] = cplValid & cntBusy[cplClass];
  end
endmodule

// File: rtl/mem_issue_gate.sv
module mem_issue_gate
  import mig_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeSel,
  input  logic                 opValid,
  input  logic [1:0]           opClass,
  output logic                 opReady,
  output logic                 issueValid,
  output logic [1:0]           issueClass,
  input  logic                 cplValid,
  input  logic [1:0]           cplClass,
  output logic                 modeActive,
  output logic [4*CNT_W-1:0]   pendCount
);
  cntStrobe_t         strobe;
  logic [NUM_CLS-1:0] cntBusy;
  logic [NUM_CLS-1:0] cntFull;

  mig_issue_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel),
    .opValid(opValid), .opClass(opClass),
    .cplValid(cplValid), .cplClass(cplClass),
    .cntBusy(cntBusy), .cntFull(cntFull),
    .opReady(opReady), .issueValid(issueValid),
    .modeActive(modeActive), .strobe(strobe)
  );

  mig_cnt_bank #(.CNT_W(CNT_W)) bank_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .pendCount(pendCount), .cntBusy(cntBusy), .cntFull(cntFull)
  );

  assign issueClass = opClass;
endmodule

// File: rtl/mem_issue_gate_chk.sv
module mem_issue_gate_chk #(
  parameter int CNT_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic               modeSel,
  input logic               opValid,
  input logic [1:0]         opClass,
  input logic               opReady,
  input logic               issueValid,
  input logic [1:0]         issueClass,
  input logic               cplValid,
  input logic [1:0]         cplClass,
  input logic               modeActive,
  input logic [4*CNT_W-1:0] pendCount
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  logic [CNT_W-1:0] cnt [4];
  logic anyBusy, specBusy;

  for (genvar g = 0; g < 4; g++) begin : g_sl
    assign cnt[g] = pendCount[g*CNT_W +: CNT_W];

    p_count_up_r8: assert property (@(posedge clk) disable iff (!rstN)
      (issueValid && issueClass == g && !(cplValid && cplClass == g))
      |=> cnt[g] == $past(cnt[g]) + 1'b1);

    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[g] == CMAX) |=> cnt[g] != '0);

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[g] == '0 && !(issueValid && issueClass == g)) |=> cnt[g] == '0);
  end

  assign anyBusy  = (pendCount != '0);
  assign specBusy = (cnt[1] != '0) || (cnt[2] != '0) || (cnt[3] != '0);

  p_weak_ord_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!modeActive && issueValid && issueClass == 2'd0) |-> !specBusy);

  p_weak_spec_ord_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!modeActive && issueValid && issueClass != 2'd0) |-> cnt[0] == '0);

  p_weak_spec_spec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!modeActive && issueValid && issueClass != 2'd0) |-> !specBusy);

  p_rel_ord_r4: assert property (@(posedge clk) disable iff (!rstN)
    (modeActive && issueValid && issueClass == 2'd0) |-> (cnt[2] == '0 && cnt[1] == '0));

  p_rel_release_r5: assert property (@(posedge clk) disable iff (!rstN)
    (modeActive && issueValid && issueClass == 2'd3) |-> !anyBusy);

  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    anyBusy |=> $stable(modeActive));

  p_handshake_r12: assert property (@(posedge clk) disable iff (!rstN)
    (issueValid == (opValid && opReady)) && (issueClass == opClass));

  logic unusedSel;
  assign unusedSel = modeSel;
endmodule

bind mem_issue_gate mem_issue_gate_chk #(.CNT_W(CNT_W)) chk_i (.*);

// File: tb/mem_issue_gate_tb_top.sv
module mem_issue_gate_tb_top;
  localparam int CNT_W = 4;
  localparam int NV = 34;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeSel = 1'b0, opValid = 1'b0, cplValid = 1'b0;
  logic [1:0] opClass = 2'd0, cplClass = 2'd0;
  logic opReady, issueValid, modeActive;
  logic [1:0] issueClass;
  logic [4*CNT_W-1:0] pendCount;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_issue_gate #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .opValid(opValid),
    .opClass(opClass), .opReady(opReady), .issueValid(issueValid),
    .issueClass(issueClass), .cplValid(cplValid), .cplClass(cplClass),
    .modeActive(modeActive), .pendCount(pendCount)
  );

  // {opValid, opClass, cplValid, cplClass, modeSel, expReady, expMode, expCount}
  // class codes: 0 ord, 1 sync, 2 acq, 3 rel; count nibbles rel|acq|sync|ord
  localparam logic [24:0] VEC [NV] = '{
    {1'b1,2'd0,1'b0,2'd0,1'b0,1'b1,1'b0,16'h0001}, // R1 R8 ord issue
    {1'b1,2'd0,1'b0,2'd0,1'b0,1'b1,1'b0,16'h0002},
    {1'b1,2'd1,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0002}, // R2
    {1'b1,2'd1,1'b1,2'd0,1'b0,1'b0,1'b0,16'h0001},
    {1'b1,2'd1,1'b1,2'd0,1'b0,1'b0,1'b0,16'h0000},
    {1'b1,2'd1,1'b0,2'd0,1'b0,1'b1,1'b0,16'h0010},
    {1'b1,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0010}, // R1
    {1'b1,2'd1,1'b0,2'd0,1'b0,1'b0,1'b0,16'h0010}, // R3
    {1'b1,2'd0,1'b1,2'd1,1'b0,1'b0,1'b0,16'h0000},
    {1'b1,2'd0,1'b0,2'd0,1'b0,1'b1,1'b0,16'h0001},
    {1'b0,2'd0,1'b1,2'd0,1'b0,1'b1,1'b0,16'h0000},
    {1'b0,2'd0,1'b0,2'd0,1'b1,1'b1,1'b1,16'h0000}, // R11 switch
    {1'b1,2'd2,1'b0,2'd0,1'b1,1'b1,1'b1,16'h0100},
    {1'b1,2'd0,1'b0,2'd0,1'b1,1'b0,1'b1,16'h0100}, // R4
    {1'b1,2'd3,1'b0,2'd0,1'b1,1'b0,1'b1,16'h0100}, // R5
    {1'b1,2'd0,1'b1,2'd2,1'b1,1'b0,1'b1,16'h0000},
    {1'b1,2'd0,1'b0,2'd0,1'b1,1'b1,1'b1,16'h0001},
    {1'b1,2'd3,1'b0,2'd0,1'b1,1'b0,1'b1,16'h0001}, // R5
    {1'b1,2'd3,1'b1,2'd0,1'b1,1'b0,1'b1,16'h0000},
    {1'b1,2'd3,1'b0,2'd0,1'b1,1'b1,1'b1,16'h1000},
    {1'b1,2'd0,1'b0,2'd0,1'b1,1'b1,1'b1,16'h1001}, // R6
    {1'b1,2'd2,1'b0,2'd0,1'b1,1'b1,1'b1,16'h1101}, // R7
    {1'b1,2'd3,1'b0,2'd0,1'b1,1'b0,1'b1,16'h1101}, // R5
    {1'b1,2'd2,1'b0,2'd0,1'b1,1'b0,1'b1,16'h1101}, // R7
    {1'b0,2'd0,1'b1,2'd3,1'b0,1'b1,1'b1,16'h0101}, // R11 hold
    {1'b0,2'd0,1'b1,2'd2,1'b0,1'b1,1'b1,16'h0001},
    {1'b0,2'd0,1'b1,2'd0,1'b0,1'b1,1'b1,16'h0000},
    {1'b0,2'd0,1'b0,2'd0,1'b0,1'b1,1'b0,16'h0000}, // R11 takes effect
    {1'b1,2'd3,1'b0,2'd0,1'b0,1'b1,1'b0,16'h1000},
    {1'b1,2'd0,1'b0,2'd0,1'b0,1'b0,1'b0,16'h1000}, // R1 rel as barrier
    {1'b0,2'd0,1'b1,2'd3,1'b0,1'b1,1'b0,16'h0000},
    {1'b0,2'd0,1'b1,2'd1,1'b0,1'b1,1'b0,16'h0000}, // R10 ignored
    {1'b1,2'd0,1'b0,2'd0,1'b0,1'b1,1'b0,16'h0001},
    {1'b1,2'd0,1'b1,2'd0,1'b0,1'b1,1'b0,16'h0001}  // R8 net zero
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    chk("R12 reset count", int'(pendCount), 0);
    chk("R12 reset mode", int'(modeActive), 0);
    chk("R12 idle ready", int'(opReady), 1);

    for (int i = 0; i < NV; i++) begin
      logic [24:0] v;
      v = VEC[i];
      opValid = v[24]; opClass = v[23:22];
      cplValid = v[21]; cplClass = v[20:19]; modeSel = v[18];
      #2;
      if (v[24]) begin
        chk($sformatf("R1-7 ready row %0d", i), int'(opReady), int'(v[17]));
        chk($sformatf("R12 issue row %0d", i), int'(issueValid), int'(v[17]));
      end
      @(posedge clk); #1;
      chk($sformatf("R8 count row %0d", i), int'(pendCount), int'(v[15:0]));
      chk($sformatf("R11 mode row %0d", i), int'(modeActive), int'(v[16]));
      @(negedge clk);
    end

    // drain the last ordinary and fill the ordinary counter (R9)
    opValid = 1'b0; cplValid = 1'b1; cplClass = 2'd0;
    @(negedge clk);
    cplValid = 1'b0; opValid = 1'b1; opClass = 2'd0;
    for (int k = 0; k < 15; k++) @(negedge clk);
    #2;
    chk("R9 full count", int'(pendCount), 15);
    chk("R9 full stalls", int'(opReady), 0);
    opClass = 2'd1; #1;
    chk("R2 sync vs full ord", int'(opReady), 0);
    opValid = 1'b0; cplValid = 1'b1; cplClass = 2'd0;
    for (int k = 0; k < 15; k++) @(negedge clk);
    cplValid = 1'b0; #2;
    chk("R10 drained", int'(pendCount), 0);

    // reset mid-flight clears counts and mode
    opValid = 1'b1; opClass = 2'd2; modeSel = 1'b1;
    @(negedge clk); @(negedge clk);
    opValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    chk("R12 reset clears count", int'(pendCount), 0);
    chk("R12 reset clears mode", int'(modeActive), 0);
    rstN = 1'b1;
    @(negedge clk);
    finishRun();
  end

  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule